// File: doc/BRIEF.md
# Six-Channel H-Bridge Gate Sequencer

This block is the digital sequencer in front of six H-bridge power stages. For each channel it turns a pair of direction inputs into four gate enables: a high-side and a low-side enable for each of the two half-bridge legs (leg A and leg B). Whenever a channel's requested mode changes, it turns every switch of that channel off for a fixed number of clock cycles before the new mode is applied. This break-before-make gap keeps the two switches of one leg from conducting through each other.

A brake-select input chooses what an open request does. With brake-select high, the channel first recirculates the winding current through both low-side switches for a timed period, and only then releases the legs. When all twelve direction inputs are low, the block is in standby: every leg is released at once and any running timed phase is cancelled. Outside standby, an over-temperature flag or an undervoltage flag releases every leg on every channel. The last two channels can also run constant-current chopping. When a digital overcurrent comparator flag reports too much current, the driving high-side switch is forced off for a minimum off-time. All analog sensing is outside the block and reaches it as synchronous flags.

The defaults assume a 100 MHz clock: a 5-cycle gap, a 100,000-cycle recirculation phase and a 200-cycle chop off-time. Every enable is a register, so each result appears one clock edge after the inputs that cause it are sampled.

Top module: `bridge_drive_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with all direction inputs low, every gate enable is low.
- R2: The mode code of a channel is {dir_a, dir_b}. In steady state, 00 releases both legs (all four enables low). 01 drives leg A low and leg B high (ls_a, hs_b). 10 drives leg A high and leg B low (hs_a, ls_b). 11 drives both legs low (ls_a, ls_b).
- R3: The high-side and low-side enables of one leg are never high in the same cycle.
- R4: Suppose a channel's mode code is sampled with a new value at clock edge E. All four of its enables are low after edges E through E+DEAD_CYC-1, and the new mode appears after edge E+DEAD_CYC. A further change during this gap restarts it from the edge where that change is sampled.
- R5: With brake_sel low, a change to code 00 leaves the channel released once the gap ends.
- R6: With brake_sel high, a change to code 00 is followed, after the gap, by REGEN_CYC cycles with both low-side enables high, and then by the released state. A non-zero code during this phase aborts it and starts a normal gap.
- R7: When all direction inputs are sampled low, every enable is low after that edge, and no recirculation phase is started or continued.
- R8: If over_temp or under_volt is sampled high outside standby, every enable of every channel is low after that edge. Once the flag clears, a channel with a non-zero code goes through the full gap before it drives again.
- R9: On the last two channels with chop_mode high, an overcurrent flag (oc_flag bit 0 for the next-to-last channel, bit 1 for the last) that is sampled high while the channel drives code 01 or 10 turns that channel's high-side enable off after that edge, and the low-side enable stays on. The high side turns back on MIN_OFF_CYC edges after the last edge at which the flag was sampled high.
- R10: With chop_mode low, the overcurrent flags have no effect on any enable.

Note: in standby the over-temperature and undervoltage shutdown is not applied, because every leg is already released there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_a | input | NUM_CH | First direction input of each channel |
| dir_b | input | NUM_CH | Second direction input of each channel |
| brake_sel | input | 1 | High: recirculate through the low sides before releasing |
| chop_mode | input | 1 | High: enable current chopping on the last two channels |
| oc_flag | input | NUM_CHOP | Overcurrent comparator flags of the chopping channels |
| over_temp | input | 1 | Over-temperature shutdown flag |
| under_volt | input | 1 | Logic-supply undervoltage flag |
| hs_a | output | NUM_CH | Leg A high-side enable |
| ls_a | output | NUM_CH | Leg A low-side enable |
| hs_b | output | NUM_CH | Leg B high-side enable |
| ls_b | output | NUM_CH | Leg B low-side enable |

## Verification
A wrong phase or timer value in a channel shows up at that channel's four enables. It appears one edge too early or too late at the end of the gap, at the end of the recirculation phase, or when the high side comes back after a chop. Each of these edges is sampled on the exact cycle the requirements give, and also one cycle before it. A target register that fails to track its input shows up as a missing gap or a missing drive pattern. The bench steps every one of the sixteen from/to transitions on all six channels to expose it. A shoot-through in any leg is caught on the very cycle it occurs.

// File: rtl/bridge_drive_pkg.sv
package bridge_drive_pkg;

  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_DEAD  = 2'd1,
    PH_REGEN = 2'd2
  } phase_t;

  localparam logic [1:0] MODE_OPEN = 2'b00;

  typedef struct packed {
    logic hs_a;
    logic ls_a;
    logic hs_b;
    logic ls_b;
  } bridge_en_t;

  function automatic bridge_en_t mode_pattern(input logic [1:0] code);
    bridge_en_t p;
    p.hs_a = code[1] & ~code[0];
    p.ls_a = code[0];
    p.hs_b = code[0] & ~code[1];
    p.ls_b = code[1];
    return p;
  endfunction

endpackage

// File: rtl/bridge_supervisor.sv
module bridge_supervisor #(
  parameter int NUM_CH = 6
) (
  input  logic [NUM_CH-1:0] dir_a,
  input  logic [NUM_CH-1:0] dir_b,
  input  logic              over_temp,
  input  logic              under_volt,
  output logic              standby,
  output logic              fault_act,
  output logic              kill
);
  // standby when every direction input is low; faults only act outside it
  assign standby   = ~(|dir_a) & ~(|dir_b);
  assign fault_act = (over_temp | under_volt) & ~standby;
  assign kill      = standby | fault_act;
endmodule

// File: rtl/bridge_channel.sv
module bridge_channel
  import bridge_drive_pkg::*;
#(
  parameter int DEAD_CYC    = 5,
  parameter int REGEN_CYC   = 100000,
  parameter int MIN_OFF_CYC = 200,
  parameter bit CHOP_EN     = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic kill,
  input  logic brake_sel,
  input  logic chop_mode,
  input  logic oc_flag,
  input  logic in_a,
  input  logic in_b,
  output logic hs_a,
  output logic ls_a,
  output logic hs_b,
  output logic ls_b
);
  localparam int SPAN = (REGEN_CYC > DEAD_CYC) ? REGEN_CYC : DEAD_CYC;
  localparam int TW   = $clog2(SPAN + 1);
  localparam int CW   = $clog2(MIN_OFF_CYC + 1);

  phase_t     ph_q, ph_d;
  logic [1:0] tgt_q, tgt_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [CW-1:0] chop_q, chop_d;
  bridge_en_t base, en_d, en_q;
  logic       chop_hit;
  logic [1:0] req;

  assign req = {in_a, in_b};

  always_comb begin
    ph_d  = ph_q;
    tgt_d = tgt_q;
    tmr_d = tmr_q;
    if (kill) begin
      ph_d  = PH_RUN;
      tgt_d = MODE_OPEN;
      tmr_d = '0;
    end else if (req != tgt_q) begin
      ph_d  = PH_DEAD;
      tgt_d = req;
      tmr_d = TW'(DEAD_CYC - 1);
    end else begin
      case (ph_q)
        PH_DEAD: begin
          if (tmr_q != '0) tmr_d = tmr_q - 1'b1;
          else if (tgt_q == MODE_OPEN && brake_sel) begin
            ph_d  = PH_REGEN;
            tmr_d = TW'(REGEN_CYC - 1);
          end else ph_d = PH_RUN;
        end
        PH_REGEN: begin
          if (tmr_q != '0) tmr_d = tmr_q - 1'b1;
          else ph_d = PH_RUN;
        end
        default: ;
      endcase
    end

    if (ph_d == PH_DEAD)       base = '0;
    else if (ph_d == PH_REGEN) base = mode_pattern(2'b11);
    else                       base = mode_pattern(tgt_d);

    chop_hit = CHOP_EN && chop_mode && oc_flag && (ph_d == PH_RUN)
               && (base.hs_a || base.hs_b);
    if (chop_hit)             chop_d = CW'(MIN_OFF_CYC);
    else if (chop_q != '0)    chop_d = chop_q - 1'b1;
    else                      chop_d = '0;

    en_d = base;
    if (chop_d != '0) begin
      en_d.hs_a = 1'b0;
      en_d.hs_b = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_RUN;
      tgt_q  <= MODE_OPEN;
      tmr_q  <= '0;
      chop_q <= '0;
      en_q   <= '0;
    end else begin
      ph_q   <= ph_d;
      tgt_q  <= tgt_d;
      tmr_q  <= tmr_d;
      chop_q <= chop_d;
      en_q   <= en_d;
    end
  end

  assign hs_a = en_q.hs_a;
  assign ls_a = en_q.ls_a;
  assign hs_b = en_q.hs_b;
  assign ls_b = en_q.ls_b;

  // R3: never both switches of one leg
  assert_no_shoot_through_R3: assert property (@(posedge clk) disable iff (rst)
    !(en_q.hs_a && en_q.ls_a) && !(en_q.hs_b && en_q.ls_b));

  // R4: low sides only change through an all-off cycle
  assert_break_before_make_R4: assert property (@(posedge clk) disable iff (rst)
    ((en_q != '0) && ($past(en_q) != '0)) |->
      (en_q.ls_a == $past(en_q.ls_a) && en_q.ls_b == $past(en_q.ls_b)));

  // R8: a kill request releases every switch at the next edge
  assert_kill_release_R8: assert property (@(posedge clk) disable iff (rst)
    kill |=> (en_q == '0));

  // R9: a sampled overcurrent removes the high side
  assert_chop_high_off_R9: assert property (@(posedge clk) disable iff (rst)
    (CHOP_EN && chop_mode && oc_flag) |=> (!en_q.hs_a && !en_q.hs_b));
endmodule

// File: rtl/bridge_drive_ctrl.sv
module bridge_drive_ctrl #(
  parameter int NUM_CH      = 6,
  parameter int NUM_CHOP    = 2,
  parameter int DEAD_CYC    = 5,
  parameter int REGEN_CYC   = 100000,
  parameter int MIN_OFF_CYC = 200
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CH-1:0]   dir_a,
  input  logic [NUM_CH-1:0]   dir_b,
  input  logic                brake_sel,
  input  logic                chop_mode,
  input  logic [NUM_CHOP-1:0] oc_flag,
  input  logic                over_temp,
  input  logic                under_volt,
  output logic [NUM_CH-1:0]   hs_a,
  output logic [NUM_CH-1:0]   ls_a,
  output logic [NUM_CH-1:0]   hs_b,
  output logic [NUM_CH-1:0]   ls_b
);
  localparam int FIRST_CHOP = NUM_CH - NUM_CHOP;

  logic standby, fault_act, kill;

  bridge_supervisor #(.NUM_CH(NUM_CH)) u_sup (
    .dir_a      (dir_a),
    .dir_b      (dir_b),
    .over_temp  (over_temp),
    .under_volt (under_volt),
    .standby    (standby),
    .fault_act  (fault_act),
    .kill       (kill)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic oc_i;
    if (i >= FIRST_CHOP) begin : g_chop
      assign oc_i = oc_flag[i - FIRST_CHOP];
    end else begin : g_plain
      assign oc_i = 1'b0;
    end
    bridge_channel #(
      .DEAD_CYC    (DEAD_CYC),
      .REGEN_CYC   (REGEN_CYC),
      .MIN_OFF_CYC (MIN_OFF_CYC),
      .CHOP_EN     (i >= FIRST_CHOP)
    ) u_ch (
      .clk       (clk),
      .rst       (rst),
      .kill      (kill),
      .brake_sel (brake_sel),
      .chop_mode (chop_mode),
      .oc_flag   (oc_i),
      .in_a      (dir_a[i]),
      .in_b      (dir_b[i]),
      .hs_a      (hs_a[i]),
      .ls_a      (ls_a[i]),
      .hs_b      (hs_b[i]),
      .ls_b      (ls_b[i])
    );
  end

  // R7: standby releases every channel at the next edge
  assert_standby_release_R7: assert property (@(posedge clk) disable iff (rst)
    standby |=> (hs_a == '0 && ls_a == '0 && hs_b == '0 && ls_b == '0));

  // R8: an active fault outside standby releases every channel
  assert_fault_release_R8: assert property (@(posedge clk) disable iff (rst)
    fault_act |=> (hs_a == '0 && ls_a == '0 && hs_b == '0 && ls_b == '0));
endmodule

// File: tb/bridge_drive_ctrl_test.sv
module bridge_drive_ctrl_test;
  localparam int NCH  = 6;
  localparam int NCP  = 2;
  localparam int DEAD = 3;
  localparam int REGN = 20;
  localparam int MOFF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] dir_a = '0, dir_b = '0;
  logic brake_sel = 1'b0, chop_mode = 1'b0;
  logic [NCP-1:0] oc_flag = '0;
  logic over_temp = 1'b0, under_volt = 1'b0;
  logic [NCH-1:0] hs_a, ls_a, hs_b, ls_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  bridge_drive_ctrl #(
    .NUM_CH(NCH), .NUM_CHOP(NCP), .DEAD_CYC(DEAD),
    .REGEN_CYC(REGN), .MIN_OFF_CYC(MOFF)
  ) uut (
    .clk(clk), .rst(rst), .dir_a(dir_a), .dir_b(dir_b),
    .brake_sel(brake_sel), .chop_mode(chop_mode), .oc_flag(oc_flag),
    .over_temp(over_temp), .under_volt(under_volt),
    .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b)
  );

  // expected enables {hs_a, ls_a, hs_b, ls_b} for a mode code {a, b}
  function automatic logic [3:0] pat(input logic [1:0] c);
    return {c[1] & ~c[0], c[0], c[0] & ~c[1], c[1]};
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_ch(input int ch, input logic [1:0] c);
    dir_a[ch] = c[1];
    dir_b[ch] = c[0];
  endtask

  task automatic chk(input int ch, input logic [3:0] exp, input string req);
    logic [3:0] act;
    act = {hs_a[ch], ls_a[ch], hs_b[ch], ls_b[ch]};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s ch%0d enables act=%b exp=%b at %0t", req, ch, act, exp, $time);
    end
  endtask

  task automatic chk_all_off(input string req);
    n_chk++;
    if ({hs_a, ls_a, hs_b, ls_b} !== '0) begin
      n_bad++;
      $display("FAIL %s all enables act=%h exp=0", req, {hs_a, ls_a, hs_b, ls_b});
    end
  endtask

  // R3: shoot-through monitor on every cycle
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_chk++;
      if (((hs_a & ls_a) | (hs_b & ls_b)) !== '0) begin
        n_bad++;
        $display("FAIL R3 shoot-through act=%b exp=0", (hs_a & ls_a) | (hs_b & ls_b));
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    chk_all_off("R1 in reset");
    rst = 1'b0;
    step(2);
    chk_all_off("R1 after reset");

    // R2, R4, R5: every transition on every channel, brake_sel low
    for (int ch = 0; ch < NCH; ch++) begin
      int h;
      h = (ch + 1) % NCH;
      dir_a = '0; dir_b = '0;
      set_ch(h, 2'b11);
      step(DEAD + 3);
      for (int f = 0; f < 4; f++) begin
        for (int t = 0; t < 4; t++) begin
          set_ch(ch, 2'(f));
          step(DEAD + 3);
          set_ch(ch, 2'(t));
          step(DEAD);
          chk(ch, (f == t) ? pat(2'(t)) : 4'b0000, "R4 gap");
          step(1);
          chk(ch, pat(2'(t)), (t == 0) ? "R5 open" : "R2 decode");
        end
      end
    end

    // R4: change inside the gap restarts it
    dir_a = '0; dir_b = '0;
    set_ch(1, 2'b11); set_ch(0, 2'b10);
    step(DEAD + 3);
    set_ch(0, 2'b01);
    step(2);
    set_ch(0, 2'b11);
    step(DEAD);
    chk(0, 4'b0000, "R4 restarted gap");
    step(1);
    chk(0, pat(2'b11), "R4 after restart");

    // R6: timed recirculation
    brake_sel = 1'b1;
    set_ch(0, 2'b10);
    step(DEAD + 3);
    set_ch(0, 2'b00);
    step(DEAD);
    chk(0, 4'b0000, "R6 gap before regen");
    step(1);
    chk(0, 4'b0101, "R6 regen start");
    step(REGN - 1);
    chk(0, 4'b0101, "R6 regen last cycle");
    step(1);
    chk(0, 4'b0000, "R6 regen end");

    // R6: abort of recirculation
    set_ch(0, 2'b10);
    step(DEAD + 3);
    set_ch(0, 2'b00);
    step(DEAD + 3);
    chk(0, 4'b0101, "R6 regen running");
    set_ch(0, 2'b01);
    step(DEAD);
    chk(0, 4'b0000, "R6 abort gap");
    step(1);
    chk(0, pat(2'b01), "R6 abort new mode");

    // R7: standby cancels recirculation
    dir_a = '0; dir_b = '0;
    set_ch(0, 2'b10);
    step(DEAD + 3);
    set_ch(0, 2'b00);
    step(1);
    chk_all_off("R7 standby entry");
    step(DEAD + 1);
    chk(0, 4'b0000, "R7 no regen in standby");
    brake_sel = 1'b0;

    // R8: over-temperature and undervoltage
    set_ch(0, 2'b10); set_ch(1, 2'b11);
    step(DEAD + 3);
    over_temp = 1'b1;
    step(1);
    chk_all_off("R8 over_temp release");
    step(5);
    chk_all_off("R8 over_temp held");
    over_temp = 1'b0;
    step(DEAD);
    chk(0, 4'b0000, "R8 gap after fault");
    step(1);
    chk(0, pat(2'b10), "R8 resume ch0");
    chk(1, pat(2'b11), "R8 resume ch1");
    under_volt = 1'b1;
    step(1);
    chk_all_off("R8 under_volt release");
    under_volt = 1'b0;
    step(DEAD + 1);
    chk(0, pat(2'b10), "R8 resume after uv");

    // R9: chopping on the next-to-last channel, one-cycle flag
    dir_a = '0; dir_b = '0;
    chop_mode = 1'b1;
    set_ch(4, 2'b10);
    set_ch(5, 2'b01);
    step(DEAD + 3);
    oc_flag[0] = 1'b1;
    step(1);
    oc_flag[0] = 1'b0;
    chk(4, 4'b0001, "R9 chop high off");
    chk(5, pat(2'b01), "R9 other channel untouched");
    step(MOFF - 1);
    chk(4, 4'b0001, "R9 min off-time");
    step(1);
    chk(4, pat(2'b10), "R9 re-enable");

    // R9: flag held three cycles on the last channel
    oc_flag[1] = 1'b1;
    step(3);
    oc_flag[1] = 1'b0;
    chk(5, 4'b0100, "R9 chop held");
    step(MOFF - 1);
    chk(5, 4'b0100, "R9 off after long flag");
    step(1);
    chk(5, pat(2'b01), "R9 re-enable after long flag");

    // R10: flags ignored with chop_mode low
    chop_mode = 1'b0;
    oc_flag = '1;
    step(2);
    chk(4, pat(2'b10), "R10 ignored ch4");
    chk(5, pat(2'b01), "R10 ignored ch5");
    oc_flag = '0;
    step(1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule